// File: doc/BRIEF.md
# UART Interrupt Cause Collector

This block gathers the five interrupt causes of a serial port and presents them, together with the modem and line state, in a single 32-bit status word. The causes are receiver line error, receive data available, receive character timeout, transmit space available and modem status change. Each cause has its own pending bit, and several can be pending at once. Software clears them one by one by writing a byte that holds the bits it has handled. Four enable bits decide which pending causes drive the single level-sensitive interrupt line.

The cause generators sit outside the block. Four of the causes arrive as one-cycle event pulses. The fifth, modem status, is raised inside the block. The four modem inputs (CTS, DSR, RI, DCD) are asynchronous. They are synchronised, then edge-detected into delta flags, and any new delta raises the modem-status cause. The line-status flags are passed through into their byte of the word. Register decode beyond this word is done elsewhere. The enable bits and the acknowledge byte write arrive already decoded.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, every bit of `statusWord` that the block holds as state is 0 (pending bits [4:0], delta bits [11:8] and synchronised levels [15:12]), and `irqOut` is 0.
- R2: An event pulse sets its pending bit on the next clock edge: line error to bit 0, data available to bit 1, character timeout to bit 2, transmit space to bit 3. The bit then holds until it is cleared.
- R3: `irqOut` is high exactly while some pending bit is set and enabled. `irqEnable` bit 0 enables pending bits 1 and 2, bit 1 enables pending bit 3, bit 2 enables pending bit 0, and bit 3 enables pending bit 4. `irqOut` follows a change of `irqEnable` in the same cycle.
- R4: A cause whose enable is off still sets its pending bit. Turning the enable on later raises `irqOut` with no new event.
- R5: A cycle with `ackWrite` high clears every pending bit whose position holds a 1 in `ackData[4:0]`. All other pending bits are left as they are.
- R6: Bits [7:5] of `ackData` have no effect. Status bits [7:5] and [31:24] always read 0.
- R7: If a cause event and the acknowledge of the same bit occur in the same cycle, the bit stays set.
- R8: The modem inputs go through two synchronising flops. A delta bit sets, together with pending bit 4, on the third clock edge after the input change. Any edge of CTS sets status bit 8, any edge of DSR sets bit 9, a falling edge of RI sets bit 10, and any edge of DCD sets bit 11. A rising edge of RI sets nothing.
- R9: Status bits [15:12] give the synchronised levels of CTS, DSR, RI and DCD, in that order, two edges after the inputs.
- R10: Clearing pending bit 4 clears all delta bits. Clearing any other pending bit leaves the deltas untouched.
- R11: Status bits [23:16] equal `lineFlags` in the same cycle: data ready, overrun, parity, framing, break, holding empty, transmitter empty and FIFO error, in bits 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineErrEvt | input | 1 | Line error event pulse |
| rxDataEvt | input | 1 | Receive data available event pulse |
| rxTimeoutEvt | input | 1 | Receive character timeout event pulse |
| txSpaceEvt | input | 1 | Transmit space available event pulse |
| modemIn | input | 4 | Asynchronous CTS, DSR, RI, DCD in bits 0 to 3 |
| lineFlags | input | 8 | Line-status flags passed to status [23:16] |
| irqEnable | input | 4 | Cause enables (see R3) |
| ackWrite | input | 1 | Byte write strobe to the pending field |
| ackData | input | 8 | Byte written; 1s clear pending bits |
| statusWord | output | 32 | Assembled status word |
| irqOut | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a pending bit that is set and acknowledged in the same edge, while the modem pipeline produces a delta in the same window. Random stimulus alone rarely lines these up. Directed steps therefore force an event together with its own acknowledge, and toggle RI in both directions. Then come acknowledges of bit 4 and of other bits, to show which of them clear the deltas. Around those steps, long random runs with sparse events, random acknowledge bytes (including bits [7:5]) and modem toggles are checked every cycle against a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W    = 5;
  localparam int MODEM_W = 4;
  localparam int EN_W    = 4;

  // pending bit positions
  localparam int ID_LINE  = 0;
  localparam int ID_DATA  = 1;
  localparam int ID_TMO   = 2;
  localparam int ID_TX    = 3;
  localparam int ID_MODEM = 4;

  // modem input positions
  localparam int MD_CTS = 0;
  localparam int MD_DSR = 1;
  localparam int MD_RI  = 2;
  localparam int MD_DCD = 3;

  typedef struct packed {
    logic [ID_W-1:0]    setId;
    logic [ID_W-1:0]    clrId;
    logic [MODEM_W-1:0] deltaSet;
    logic               deltaClr;
  } irqStrobe_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineErrEvt,
  input  logic               rxDataEvt,
  input  logic               rxTimeoutEvt,
  input  logic               txSpaceEvt,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               ackWrite,
  input  logic [7:0]         ackData,
  output irqStrobe_t         strobe,
  output logic [MODEM_W-1:0] modemLevel
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][MODEM_W-1:0] syncChain;
  logic [MODEM_W-1:0] prevLevel;
  logic [MODEM_W-1:0] anyEdge;
  logic [MODEM_W-1:0] deltaSet;
  logic [ID_W-1:0]    clrMask;
  logic               unusedAckHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= modemIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= '0;
    else       prevLevel <= syncChain[LAST];
  end

  assign modemLevel = syncChain[LAST];
  assign anyEdge    = syncChain[LAST] ^ prevLevel;

  always_comb begin
    deltaSet         = anyEdge;
    deltaSet[MD_RI]  = prevLevel[MD_RI] & ~syncChain[LAST][MD_RI];
  end

  assign clrMask     = ackWrite ? ackData[ID_W-1:0] : '0;
  assign unusedAckHi = ^ackData[7:ID_W];

  always_comb begin
    strobe                 = '0;
    strobe.setId[ID_LINE]  = lineErrEvt;
    strobe.setId[ID_DATA]  = rxDataEvt;
    strobe.setId[ID_TMO]   = rxTimeoutEvt;
    strobe.setId[ID_TX]    = txSpaceEvt;
    strobe.setId[ID_MODEM] = |deltaSet;
    strobe.clrId           = clrMask;
    strobe.deltaSet        = deltaSet;
    strobe.deltaClr        = clrMask[ID_MODEM];
  end

  // R8: a rising RI must not request a ring delta
  assert_ri_rise_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (syncChain[LAST][MD_RI] && !prevLevel[MD_RI]) |-> !strobe.deltaSet[MD_RI]);
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [EN_W-1:0]    irqEnable,
  input  logic [MODEM_W-1:0] modemLevel,
  input  logic [7:0]         lineFlags,
  output logic [31:0]        statusWord,
  output logic               irqOut
);
  logic [ID_W-1:0]    idReg;
  logic [MODEM_W-1:0] deltaReg;
  logic [ID_W-1:0]    gateMask;

  generate
    for (genvar i = 0; i < ID_W; i++) begin : g_id
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) idReg[i] <= 1'b0;
        else       idReg[i] <= (idReg[i] & ~strobe.clrId[i]) | strobe.setId[i];
      end

      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
        strobe.setId[i] |=> idReg[i]);
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.clrId[i] && !strobe.setId[i]) |=> !idReg[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.clrId[i] && !strobe.setId[i]) |=> $stable(idReg[i]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deltaReg <= '0;
    else       deltaReg <= (deltaReg & ~{MODEM_W{strobe.deltaClr}}) | strobe.deltaSet;
  end

  always_comb begin
    gateMask           = '0;
    gateMask[ID_LINE]  = irqEnable[2];
    gateMask[ID_DATA]  = irqEnable[0];
    gateMask[ID_TMO]   = irqEnable[0];
    gateMask[ID_TX]    = irqEnable[1];
    gateMask[ID_MODEM] = irqEnable[3];
  end

  assign irqOut     = |(idReg & gateMask);
  assign statusWord = {8'h00, lineFlags, modemLevel, deltaReg, 3'b000, idReg};

  // R10: a delta never outlives the modem-status pending bit
  assert_delta_needs_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|deltaReg) |-> idReg[ID_MODEM]);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineErrEvt,
  input  logic        rxDataEvt,
  input  logic        rxTimeoutEvt,
  input  logic        txSpaceEvt,
  input  logic [3:0]  modemIn,
  input  logic [7:0]  lineFlags,
  input  logic [3:0]  irqEnable,
  input  logic        ackWrite,
  input  logic [7:0]  ackData,
  output logic [31:0] statusWord,
  output logic        irqOut
);
  irqStrobe_t         strobe;
  logic [MODEM_W-1:0] modemLevel;

  uart_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lineErrEvt(lineErrEvt), .rxDataEvt(rxDataEvt),
    .rxTimeoutEvt(rxTimeoutEvt), .txSpaceEvt(txSpaceEvt),
    .modemIn(modemIn), .ackWrite(ackWrite), .ackData(ackData),
    .strobe(strobe), .modemLevel(modemLevel)
  );

  uart_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqEnable(irqEnable),
    .modemLevel(modemLevel), .lineFlags(lineFlags),
    .statusWord(statusWord), .irqOut(irqOut)
  );

  assert_irq_needs_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusWord[4:0] != 5'd0));
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[7:5] == 3'd0) && (statusWord[31:24] == 8'd0));
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineErrEvt = 0, rxDataEvt = 0, rxTimeoutEvt = 0, txSpaceEvt = 0;
  logic [3:0]  modemIn = '0;
  logic [7:0]  lineFlags = '0;
  logic [3:0]  irqEnable = '0;
  logic        ackWrite = 0;
  logic [7:0]  ackData = '0;
  logic [31:0] statusWord;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // bench model state
  logic [4:0] expId = '0;
  logic [3:0] expDelta = '0;
  logic [3:0] mS0 = '0, mS1 = '0, mPrev = '0;

  always #4 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rstN(rstN), .lineErrEvt(lineErrEvt), .rxDataEvt(rxDataEvt),
    .rxTimeoutEvt(rxTimeoutEvt), .txSpaceEvt(txSpaceEvt), .modemIn(modemIn),
    .lineFlags(lineFlags), .irqEnable(irqEnable), .ackWrite(ackWrite),
    .ackData(ackData), .statusWord(statusWord), .irqOut(irqOut)
  );

  function automatic logic calcIrq(input logic [4:0] id, input logic [3:0] en);
    logic [4:0] m;
    m = {en[3], en[1], en[0], en[0], en[2]};
    return |(id & m);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    check("R2 R5 R7 pending field", {27'd0, statusWord[4:0]}, {27'd0, expId});
    check("R8 R10 delta bits", {28'd0, statusWord[11:8]}, {28'd0, expDelta});
    check("R9 modem levels", {28'd0, statusWord[15:12]}, {28'd0, mS1});
    check("R11 line byte", {24'd0, statusWord[23:16]}, {24'd0, lineFlags});
    check("R6 reserved bits", {statusWord[31:24], 21'd0, statusWord[7:5]}, 32'd0);
    check("R3 irq level", {31'd0, irqOut}, {31'd0, calcIrq(expId, irqEnable)});
  endtask

  // at a negedge: check, drive, advance model, wait to next negedge
  task automatic step(input logic [3:0] evt, input logic aw, input logic [7:0] ad,
                      input logic [3:0] en, input logic [3:0] md, input logic [7:0] lf);
    logic [3:0] edges, dSet;
    logic [4:0] clr;
    compareModel();
    {txSpaceEvt, rxTimeoutEvt, rxDataEvt, lineErrEvt} = evt;
    ackWrite = aw; ackData = ad; irqEnable = en; modemIn = md; lineFlags = lf;
    edges = mS1 ^ mPrev;
    dSet = {edges[3], mPrev[2] & ~mS1[2], edges[1], edges[0]};
    clr = aw ? ad[4:0] : 5'd0;
    expId = (expId & ~clr) | {|dSet, evt};
    expDelta = (expDelta & ~{4{clr[4]}}) | dSet;
    mPrev = mS1; mS1 = mS0; mS0 = md;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [3:0] en, input logic [3:0] md);
    for (int k = 0; k < n; k++) step(4'b0, 1'b0, 8'h00, en, md, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [3:0] en, md;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status after reset", statusWord, 32'd0);
    check("R1 irq after reset", {31'd0, irqOut}, 32'd0);

    // R4: disabled cause still latches
    step(4'b0010, 0, 8'h00, 4'b0000, 4'b0, 8'h00);
    check("R4 latched while disabled", {27'd0, statusWord[4:0]}, 32'h02);
    check("R4 irq low while disabled", {31'd0, irqOut}, 32'd0);
    // R3: enabling raises irq in the same cycle
    irqEnable = 4'b0001; #1;
    check("R3 enable raises irq", {31'd0, irqOut}, 32'd1);
    // R6: bits 7:5 written as ones do nothing
    step(4'b0, 1, 8'hE0, 4'b0001, 4'b0, 8'h00);
    check("R6 high ack bits ignored", {27'd0, statusWord[4:0]}, 32'h02);
    // R7: event with its own acknowledge keeps the bit
    step(4'b0010, 1, 8'h02, 4'b0001, 4'b0, 8'h00);
    check("R7 set wins over clear", {27'd0, statusWord[4:0]}, 32'h02);
    // R5: selective clear
    step(4'b1001, 0, 8'h00, 4'b0001, 4'b0, 8'h00);
    step(4'b0, 1, 8'h03, 4'b0001, 4'b0, 8'h00);
    check("R5 selective clear", {27'd0, statusWord[4:0]}, 32'h08);
    check("R5 irq drops", {31'd0, irqOut}, 32'd0);
    step(4'b0, 1, 8'h08, 4'b0001, 4'b0, 8'hA5);
    check("R11 line byte passthrough", {24'd0, statusWord[23:16]}, 32'hA5);
    // R8: RI rising sets no delta; R9 level follows
    idle(4, 4'b1000, 4'b0100);
    check("R8 RI rise no delta", {27'd0, statusWord[4:0]}, 32'd0);
    check("R8 RI rise no delta bits", {28'd0, statusWord[11:8]}, 32'd0);
    check("R9 RI level", {28'd0, statusWord[15:12]}, 32'h4);
    // R8: RI falling and CTS edge set deltas; timing on third edge
    step(4'b0, 0, 8'h00, 4'b1000, 4'b0001, 8'h00);
    step(4'b0, 0, 8'h00, 4'b1000, 4'b0001, 8'h00);
    check("R8 delta not yet after two edges", {28'd0, statusWord[11:8]}, 32'd0);
    step(4'b0, 0, 8'h00, 4'b1000, 4'b0001, 8'h00);
    check("R8 deltas on third edge", {28'd0, statusWord[11:8]}, 32'h5);
    check("R8 modem pending", {27'd0, statusWord[4:0]}, 32'h10);
    check("R3 modem irq", {31'd0, irqOut}, 32'd1);
    // R10: other clear keeps deltas, bit 4 clear removes them
    step(4'b0, 1, 8'h01, 4'b1000, 4'b0001, 8'h00);
    check("R10 deltas kept", {28'd0, statusWord[11:8]}, 32'h5);
    step(4'b0, 1, 8'h10, 4'b1000, 4'b0001, 8'h00);
    check("R10 deltas cleared", {28'd0, statusWord[11:8]}, 32'd0);

    // random phase
    en = 4'hF; md = 4'b0001;
    for (int c = 0; c < 4000; c++) begin
      logic [3:0] evt;
      logic aw;
      evt = 4'b0;
      for (int b = 0; b < 4; b++) evt[b] = ($urandom_range(0, 7) == 0);
      aw = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 31) == 0) en = 4'($urandom);
      if ($urandom_range(0, 15) == 0) md[$urandom_range(0, 3)] ^= 1'b1;
      step(evt, aw, 8'($urandom), en, md, 8'($urandom));
    end
    compareModel();

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule